// File: doc/BRIEF.md
# Combining Butterfly Routing Switch

This block is one two-by-two node of a butterfly network that carries memory requests from processors toward memory modules. Each input delivers a stream of request packets, each with a target address, a read/write flag and a data word, and each stream arrives sorted by address. The node merges its two streams into two output streams that stay sorted. It picks the output for each packet from one address bit, chosen by the node's column. It never lets a packet leave while a smaller address could still turn up on the other input. Two reads or two writes to the same address meet at the heads of the two inputs; the node folds them into one packet.

A round of requests ends with an end-of-round marker on each input. The marker ranks above every address, so it also closes off the sort. The node keeps a marker until the other input has delivered its own marker, and then sends one marker down each output. For every read it forwards, the node logs in a first-in first-out direction queue which output the read took, which input it came from and whether it was merged. Replies coming back from the two outputs are consumed in that logged order. A reply is sent to the recorded input, or copied to both inputs when the read was merged.

Top module: `comb_route_node`

## Requirements
- R1: A forwarded request leaves on output 1 when bit COL of its address is 1, and on output 0 when that bit is 0 (default COL = 2).
- R2: With a request at the head of both inputs, the one with the smaller address is forwarded first. Between end-of-round markers, the addresses on each output never decrease.
- R3: A request is forwarded only while both inputs hold a packet. A request that is alone in the node stays there.
- R4: Two heads with equal addresses and the same read/write flag are merged into a single packet. For two writes, the data of input 0 is kept.
- R5: An input packet with its eor flag set is an end-of-round marker and ranks above every address. It is held until the other input also presents a marker. Both markers are then consumed, and exactly one marker leaves on each output.
- R6: Each forwarded read adds one direction-queue entry. The oldest entry takes the next reply from the output side the read left on. The reply goes to the input side the read came from, or to both input sides (rout0 and rout1, same data, same cycle) when the read was merged.
- R7: A forwarded write adds no direction-queue entry, so the next reply is steered by the next read only.
- R8: An output packet that is not accepted (valid high, ready low) stays unchanged. Forwarding toward it stops, and an input's ready goes low once its two-entry buffer is full.
- R9: After reset both outputs and both reply outputs are idle, and both request inputs and both reply inputs are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in0_valid | input | 1 | Request input 0 valid |
| in0_ready | output | 1 | Request input 0 can accept |
| in0_eor | input | 1 | Input 0 packet is an end-of-round marker |
| in0_wr | input | 1 | Input 0 packet is a write (0 = read) |
| in0_dest | input | ADDR_W | Input 0 target address |
| in0_data | input | DATA_W | Input 0 write data |
| in1_valid | input | 1 | Request input 1 valid |
| in1_ready | output | 1 | Request input 1 can accept |
| in1_eor | input | 1 | Input 1 end-of-round marker |
| in1_wr | input | 1 | Input 1 write flag |
| in1_dest | input | ADDR_W | Input 1 target address |
| in1_data | input | DATA_W | Input 1 write data |
| out0_valid | output | 1 | Output 0 packet valid |
| out0_ready | input | 1 | Output 0 accepted downstream |
| out0_eor | output | 1 | Output 0 end-of-round marker |
| out0_wr | output | 1 | Output 0 write flag |
| out0_dest | output | ADDR_W | Output 0 address |
| out0_data | output | DATA_W | Output 0 data |
| out1_valid | output | 1 | Output 1 packet valid |
| out1_ready | input | 1 | Output 1 accepted downstream |
| out1_eor | output | 1 | Output 1 end-of-round marker |
| out1_wr | output | 1 | Output 1 write flag |
| out1_dest | output | ADDR_W | Output 1 address |
| out1_data | output | DATA_W | Output 1 data |
| rin0_valid | input | 1 | Reply arriving from the output-0 side |
| rin0_ready | output | 1 | Reply buffer 0 can accept |
| rin0_data | input | DATA_W | Reply data from the output-0 side |
| rin1_valid | input | 1 | Reply arriving from the output-1 side |
| rin1_ready | output | 1 | Reply buffer 1 can accept |
| rin1_data | input | DATA_W | Reply data from the output-1 side |
| rout0_valid | output | 1 | Reply to the input-0 side, one-cycle pulse |
| rout0_data | output | DATA_W | Reply data to the input-0 side |
| rout1_valid | output | 1 | Reply to the input-1 side, one-cycle pulse |
| rout1_data | output | DATA_W | Reply data to the input-1 side |

## Verification
The ordering assertion relies on each input stream arriving sorted by address within a round, with a marker closing every round. The reply assertion relies on replies coming back on an output side only for reads that actually left on that side. The directed stimulus keeps to both conditions: every scenario feeds sorted requests, closes the round with a marker on both inputs, and returns exactly one reply per forwarded read, on the side that read was routed to. Back-pressure is applied only on the output-ready pins.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IN0,
    SEL_IN1,
    SEL_MERGE,
    SEL_EOR
  } sel_e;

  typedef struct packed {
    logic side;   // output the read left on
    logic comb;   // read was merged from both inputs
    logic src;    // input the read came from
  } dq_ent_t;

  localparam int DQ_W = $bits(dq_ent_t);
endpackage

// File: rtl/rn_fifo.sv
module rn_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  output logic         pop_valid,
  input  logic         pop,
  output logic [W-1:0] pop_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign push_ready = (cnt < CW'(DEPTH));
  assign pop_valid  = (cnt != '0);
  assign pop_data   = mem[rp];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && pop_valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // the control above must never pop an empty buffer
  AST_FIFO_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> pop_valid) else $error("pop on empty buffer"); // R8
endmodule

// File: rtl/rn_cmp.sv
module rn_cmp #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic          lt,
  output logic          eq
);
  logic [AW:0] diff;

  assign diff = {1'b0, a} - {1'b0, b};
  assign lt   = diff[AW];
  assign eq   = (diff == '0);
endmodule

// File: rtl/rn_out_reg.sv
module rn_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         space,
  output logic         o_valid,
  input  logic         o_ready,
  output logic [W-1:0] o_data
);
  assign space = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
    end else if (load) begin
      o_valid <= 1'b1;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) o_data <= load_data;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data))) else $error("output changed while stalled"); // R8
endmodule

// File: rtl/comb_route_node.sv
module comb_route_node #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int COL      = 2,
  parameter int BUF_D    = 2,
  parameter int DQ_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in0_valid,
  output logic              in0_ready,
  input  logic              in0_eor,
  input  logic              in0_wr,
  input  logic [ADDR_W-1:0] in0_dest,
  input  logic [DATA_W-1:0] in0_data,
  input  logic              in1_valid,
  output logic              in1_ready,
  input  logic              in1_eor,
  input  logic              in1_wr,
  input  logic [ADDR_W-1:0] in1_dest,
  input  logic [DATA_W-1:0] in1_data,
  output logic              out0_valid,
  input  logic              out0_ready,
  output logic              out0_eor,
  output logic              out0_wr,
  output logic [ADDR_W-1:0] out0_dest,
  output logic [DATA_W-1:0] out0_data,
  output logic              out1_valid,
  input  logic              out1_ready,
  output logic              out1_eor,
  output logic              out1_wr,
  output logic [ADDR_W-1:0] out1_dest,
  output logic [DATA_W-1:0] out1_data,
  input  logic              rin0_valid,
  output logic              rin0_ready,
  input  logic [DATA_W-1:0] rin0_data,
  input  logic              rin1_valid,
  output logic              rin1_ready,
  input  logic [DATA_W-1:0] rin1_data,
  output logic              rout0_valid,
  output logic [DATA_W-1:0] rout0_data,
  output logic              rout1_valid,
  output logic [DATA_W-1:0] rout1_data
);
  import rn_pkg::*;

  localparam int PW     = 2 + ADDR_W + DATA_W;
  localparam int EOR_B  = PW - 1;
  localparam int WR_B   = PW - 2;
  localparam int DST_LO = DATA_W;
  localparam int DST_HI = DATA_W + ADDR_W - 1;

  // request input buffers
  logic [PW-1:0] in_pk [2];
  logic [PW-1:0] hd    [2];
  logic [1:0]    in_v, in_rdy, hv, pop;

  assign in_pk[0] = {in0_eor, in0_wr, in0_dest, in0_data};
  assign in_pk[1] = {in1_eor, in1_wr, in1_dest, in1_data};
  assign in_v      = {in1_valid, in0_valid};
  assign in0_ready = in_rdy[0];
  assign in1_ready = in_rdy[1];

  for (genvar k = 0; k < 2; k++) begin : g_inbuf
    rn_fifo #(.W(PW), .DEPTH(BUF_D)) u_buf (
      .clk(clk), .rst(rst),
      .push_valid(in_v[k]), .push_ready(in_rdy[k]), .push_data(in_pk[k]),
      .pop_valid(hv[k]), .pop(pop[k]), .pop_data(hd[k])
    );
  end

  // head fields
  logic              e0, e1, w0, w1;
  logic [ADDR_W-1:0] d0, d1;
  logic              lt, eq;

  assign e0 = hd[0][EOR_B];
  assign e1 = hd[1][EOR_B];
  assign w0 = hd[0][WR_B];
  assign w1 = hd[1][WR_B];
  assign d0 = hd[0][DST_HI:DST_LO];
  assign d1 = hd[1][DST_HI:DST_LO];

  rn_cmp #(.AW(ADDR_W)) u_cmp (.a(d0), .b(d1), .lt(lt), .eq(eq));

  // direction queue
  logic    dq_push, dq_rdy, dq_v, dq_pop;
  dq_ent_t dq_in, dqh;
  logic [DQ_W-1:0] dq_raw;

  rn_fifo #(.W(DQ_W), .DEPTH(DQ_DEPTH)) u_dirq (
    .clk(clk), .rst(rst),
    .push_valid(dq_push), .push_ready(dq_rdy), .push_data(dq_in),
    .pop_valid(dq_v), .pop(dq_pop), .pop_data(dq_raw)
  );
  assign dqh = dq_ent_t'(dq_raw);

  // forward decision
  sel_e          sel;
  logic [1:0]    ld, sp;
  logic [PW-1:0] ld_pk;
  logic          side;

  always_comb begin
    sel = SEL_NONE;
    if (hv[0] && hv[1]) begin
      if (e0 && e1)              sel = SEL_EOR;
      else if (e0)               sel = SEL_IN1;
      else if (e1)               sel = SEL_IN0;
      else if (eq && (w0 == w1)) sel = SEL_MERGE;
      else if (lt || eq)         sel = SEL_IN0;
      else                       sel = SEL_IN1;
    end
  end

  always_comb begin
    pop     = 2'b00;
    ld      = 2'b00;
    ld_pk   = hd[0];
    dq_push = 1'b0;
    dq_in   = '0;
    side    = 1'b0;
    case (sel)
      SEL_EOR: begin
        if (sp[0] && sp[1]) begin
          pop = 2'b11;
          ld  = 2'b11;
        end
      end
      SEL_IN0, SEL_MERGE: begin
        side = d0[COL];
        if (sp[side] && (w0 || dq_rdy)) begin
          pop[0]   = 1'b1;
          pop[1]   = (sel == SEL_MERGE);
          ld[side] = 1'b1;
          dq_push  = !w0;
          dq_in    = '{side: side, comb: (sel == SEL_MERGE), src: 1'b0};
        end
      end
      SEL_IN1: begin
        side  = d1[COL];
        ld_pk = hd[1];
        if (sp[side] && (w1 || dq_rdy)) begin
          pop[1]   = 1'b1;
          ld[side] = 1'b1;
          dq_push  = !w1;
          dq_in    = '{side: side, comb: 1'b0, src: 1'b1};
        end
      end
      default: ;
    endcase
  end

  // output stages
  logic [1:0]    ov, ordy;
  logic [PW-1:0] od [2];

  assign ordy = {out1_ready, out0_ready};

  for (genvar k = 0; k < 2; k++) begin : g_out
    rn_out_reg #(.W(PW)) u_oreg (
      .clk(clk), .rst(rst),
      .load(ld[k]), .load_data(ld_pk), .space(sp[k]),
      .o_valid(ov[k]), .o_ready(ordy[k]), .o_data(od[k])
    );
  end

  assign out0_valid = ov[0];
  assign out0_eor   = od[0][EOR_B];
  assign out0_wr    = od[0][WR_B];
  assign out0_dest  = od[0][DST_HI:DST_LO];
  assign out0_data  = od[0][DATA_W-1:0];
  assign out1_valid = ov[1];
  assign out1_eor   = od[1][EOR_B];
  assign out1_wr    = od[1][WR_B];
  assign out1_dest  = od[1][DST_HI:DST_LO];
  assign out1_data  = od[1][DATA_W-1:0];

  // reply path
  logic [DATA_W-1:0] rin_d [2];
  logic [DATA_W-1:0] rh    [2];
  logic [1:0]        rin_v, rin_rdy, rhv, rpop;
  logic              rfire;

  assign rin_d[0]   = rin0_data;
  assign rin_d[1]   = rin1_data;
  assign rin_v      = {rin1_valid, rin0_valid};
  assign rin0_ready = rin_rdy[0];
  assign rin1_ready = rin_rdy[1];

  for (genvar k = 0; k < 2; k++) begin : g_rbuf
    rn_fifo #(.W(DATA_W), .DEPTH(BUF_D)) u_rbuf (
      .clk(clk), .rst(rst),
      .push_valid(rin_v[k]), .push_ready(rin_rdy[k]), .push_data(rin_d[k]),
      .pop_valid(rhv[k]), .pop(rpop[k]), .pop_data(rh[k])
    );
    assign rpop[k] = rfire && (dqh.side == 1'(k));
  end

  assign rfire  = dq_v && rhv[dqh.side];
  assign dq_pop = rfire;

  always_ff @(posedge clk) begin
    if (rst) begin
      rout0_valid <= 1'b0;
      rout1_valid <= 1'b0;
    end else begin
      rout0_valid <= rfire && (dqh.comb || !dqh.src);
      rout1_valid <= rfire && (dqh.comb ||  dqh.src);
    end
  end

  always_ff @(posedge clk) begin
    if (rfire) begin
      rout0_data <= rh[dqh.side];
      rout1_data <= rh[dqh.side];
    end
  end

  // ordering trackers for the sort check
  logic [1:0]        seen;
  logic [ADDR_W-1:0] last [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 2'b00;
      last[0] <= '0;
      last[1] <= '0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (ov[k] && ordy[k]) begin
          if (od[k][EOR_B]) seen[k] <= 1'b0;
          else begin
            seen[k] <= 1'b1;
            last[k] <= od[k][DST_HI:DST_LO];
          end
        end
      end
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_chk
    AST_SORTED_OUT: assert property (@(posedge clk) disable iff (rst)
      (ov[k] && ordy[k] && !od[k][EOR_B] && seen[k]) |-> (od[k][DST_HI:DST_LO] >= last[k]))
      else $error("output stream out of order"); // R2
  end

  AST_ROUTE_BIT: assert property (@(posedge clk) disable iff (rst)
    (out1_valid && !out1_eor) |-> out1_dest[COL]) else $error("wrong output for address"); // R1

  AST_EOR_HELD: assert property (@(posedge clk) disable iff (rst)
    (hv[0] && e0 && !(hv[1] && e1)) |=> (hv[0] && hd[0][EOR_B])) else $error("marker left alone"); // R5

  AST_REPLY_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (rout0_valid || rout1_valid) |-> $past(dq_v)) else $error("reply without queue entry"); // R6
endmodule

// File: tb/comb_route_node_tb_top.sv
`timescale 1ns/1ps
module comb_route_node_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          in_valid [2];
  logic          in_eor   [2];
  logic          in_wr    [2];
  logic [AW-1:0] in_dest  [2];
  logic [DW-1:0] in_data  [2];
  logic          in0_ready, in1_ready;
  logic          out0_valid, out1_valid, out0_eor, out1_eor, out0_wr, out1_wr;
  logic [AW-1:0] out0_dest, out1_dest;
  logic [DW-1:0] out0_data, out1_data;
  logic          out0_ready = 1'b1, out1_ready = 1'b1;
  logic          rin_valid [2];
  logic [DW-1:0] rin_data  [2];
  logic          rin0_ready, rin1_ready;
  logic          rout0_valid, rout1_valid;
  logic [DW-1:0] rout0_data, rout1_data;

  comb_route_node dut_i (
    .clk(clk), .rst(rst),
    .in0_valid(in_valid[0]), .in0_ready(in0_ready), .in0_eor(in_eor[0]), .in0_wr(in_wr[0]),
    .in0_dest(in_dest[0]), .in0_data(in_data[0]),
    .in1_valid(in_valid[1]), .in1_ready(in1_ready), .in1_eor(in_eor[1]), .in1_wr(in_wr[1]),
    .in1_dest(in_dest[1]), .in1_data(in_data[1]),
    .out0_valid(out0_valid), .out0_ready(out0_ready), .out0_eor(out0_eor), .out0_wr(out0_wr),
    .out0_dest(out0_dest), .out0_data(out0_data),
    .out1_valid(out1_valid), .out1_ready(out1_ready), .out1_eor(out1_eor), .out1_wr(out1_wr),
    .out1_dest(out1_dest), .out1_data(out1_data),
    .rin0_valid(rin_valid[0]), .rin0_ready(rin0_ready), .rin0_data(rin_data[0]),
    .rin1_valid(rin_valid[1]), .rin1_ready(rin1_ready), .rin1_data(rin_data[1]),
    .rout0_valid(rout0_valid), .rout0_data(rout0_data),
    .rout1_valid(rout1_valid), .rout1_data(rout1_data)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // captured traffic
  int            n_out [2];
  logic [AW-1:0] lg_dest [2][32];
  logic          lg_eor  [2][32];
  logic          lg_wr   [2][32];
  logic [DW-1:0] lg_data [2][32];
  int            n_rep [2];
  logic [DW-1:0] rp_data [2][8];

  always @(negedge clk) begin
    if (!rst) begin
      if (out0_valid && out0_ready && n_out[0] < 32) begin
        lg_dest[0][n_out[0]] = out0_dest; lg_eor[0][n_out[0]] = out0_eor;
        lg_wr[0][n_out[0]] = out0_wr; lg_data[0][n_out[0]] = out0_data;
        n_out[0]++;
      end
      if (out1_valid && out1_ready && n_out[1] < 32) begin
        lg_dest[1][n_out[1]] = out1_dest; lg_eor[1][n_out[1]] = out1_eor;
        lg_wr[1][n_out[1]] = out1_wr; lg_data[1][n_out[1]] = out1_data;
        n_out[1]++;
      end
      if (rout0_valid && n_rep[0] < 8) begin rp_data[0][n_rep[0]] = rout0_data; n_rep[0]++; end
      if (rout1_valid && n_rep[1] < 8) begin rp_data[1][n_rep[1]] = rout1_data; n_rep[1]++; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_out[0] = 0; n_out[1] = 0; n_rep[0] = 0; n_rep[1] = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv(input int s, input bit e, input bit w, input logic [AW-1:0] d, input logic [DW-1:0] x);
    bit ok;
    in_valid[s] = 1'b1; in_eor[s] = e; in_wr[s] = w; in_dest[s] = d; in_data[s] = x;
    do begin
      ok = (s == 0) ? in0_ready : in1_ready;
      @(negedge clk);
    end while (!ok);
    in_valid[s] = 1'b0;
  endtask

  task automatic rep_drv(input int s, input logic [DW-1:0] x);
    bit ok;
    rin_valid[s] = 1'b1; rin_data[s] = x;
    do begin
      ok = (s == 0) ? rin0_ready : rin1_ready;
      @(negedge clk);
    end while (!ok);
    rin_valid[s] = 1'b0;
  endtask

  task automatic t_reset();
    chk(!out0_valid && !out1_valid, "R9 outputs idle", {out1_valid, out0_valid}, 0);
    chk(in0_ready && in1_ready && rin0_ready && rin1_ready, "R9 inputs ready",
        {rin1_ready, rin0_ready, in1_ready, in0_ready}, 4'hf);
    chk(!rout0_valid && !rout1_valid, "R9 replies idle", {rout1_valid, rout0_valid}, 0);
  endtask

  task automatic t_sort_wait();
    clear_logs();
    fork
      drv(0, 0, 1, 8'h30, 16'h000a);
      drv(1, 0, 1, 8'h10, 16'h000b);
    join
    idle(6);
    chk(n_out[0] == 1, "R3 only one forwarded while other input empty", n_out[0], 1);
    chk(lg_dest[0][0] == 8'h10, "R2 smaller address first", lg_dest[0][0], 8'h10);
    drv(1, 1, 0, 8'h00, 16'h0);
    idle(6);
    chk(n_out[0] == 2 && lg_dest[0][1] == 8'h30, "R2 larger address after marker arrives", lg_dest[0][1], 8'h30);
    drv(0, 1, 0, 8'h00, 16'h0);
    idle(6);
    chk(n_out[0] == 3 && lg_eor[0][2], "R5 marker on output 0", n_out[0], 3);
    chk(n_out[1] == 1 && lg_eor[1][0], "R5 marker on output 1", n_out[1], 1);
  endtask

  task automatic t_route();
    clear_logs();
    fork
      drv(0, 0, 1, 8'h04, 16'h0001);
      drv(1, 0, 1, 8'h09, 16'h0002);
    join
    fork
      drv(0, 1, 0, 8'h00, 16'h0);
      drv(1, 1, 0, 8'h00, 16'h0);
    join
    idle(6);
    chk(n_out[1] == 2 && lg_dest[1][0] == 8'h04 && lg_eor[1][1], "R1 bit2=1 to output 1", lg_dest[1][0], 8'h04);
    chk(n_out[0] == 2 && lg_dest[0][0] == 8'h09 && lg_eor[0][1], "R1 bit2=0 to output 0", lg_dest[0][0], 8'h09);
  endtask

  task automatic t_eor_hold();
    clear_logs();
    drv(0, 1, 0, 8'h00, 16'h0);
    idle(8);
    chk(n_out[0] == 0 && n_out[1] == 0, "R5 lone marker held", n_out[0] + n_out[1], 0);
    drv(1, 1, 0, 8'h00, 16'h0);
    idle(6);
    chk(n_out[0] == 1 && n_out[1] == 1 && lg_eor[0][0] && lg_eor[1][0], "R5 one marker per output",
        n_out[0] + n_out[1], 2);
  endtask

  task automatic t_merge_read();
    clear_logs();
    fork
      drv(0, 0, 0, 8'h24, 16'h0);
      drv(1, 0, 0, 8'h24, 16'h0);
    join
    fork
      drv(0, 1, 0, 8'h00, 16'h0);
      drv(1, 1, 0, 8'h00, 16'h0);
    join
    idle(6);
    chk(n_out[1] == 2 && lg_dest[1][0] == 8'h24 && !lg_wr[1][0] && !lg_eor[1][0] && lg_eor[1][1],
        "R4 two reads merged into one", n_out[1], 2);
    rep_drv(1, 16'hbeef);
    idle(5);
    chk(n_rep[0] == 1 && n_rep[1] == 1, "R6 merged reply copied to both inputs", n_rep[0] + n_rep[1], 2);
    chk(rp_data[0][0] == 16'hbeef && rp_data[1][0] == 16'hbeef, "R6 merged reply data", rp_data[0][0], 16'hbeef);
  endtask

  task automatic t_single_read();
    clear_logs();
    fork
      drv(1, 0, 0, 8'h08, 16'h0);
      drv(0, 1, 0, 8'h00, 16'h0);
    join
    drv(1, 1, 0, 8'h00, 16'h0);
    idle(6);
    chk(n_out[0] == 2 && lg_dest[0][0] == 8'h08, "R6 read forwarded on output 0", lg_dest[0][0], 8'h08);
    rep_drv(0, 16'h1234);
    idle(5);
    chk(n_rep[0] == 0 && n_rep[1] == 1 && rp_data[1][0] == 16'h1234, "R6 reply to recorded input 1",
        {n_rep[1], n_rep[0]}, 16'h0010);
  endtask

  task automatic t_write_merge();
    clear_logs();
    fork
      drv(0, 0, 1, 8'h40, 16'h1111);
      drv(1, 0, 1, 8'h40, 16'h2222);
    join
    fork
      drv(1, 0, 0, 8'h48, 16'h0);
      drv(0, 1, 0, 8'h00, 16'h0);
    join
    drv(1, 1, 0, 8'h00, 16'h0);
    idle(6);
    chk(n_out[0] == 3 && lg_dest[0][0] == 8'h40 && lg_wr[0][0], "R4 two writes merged", n_out[0], 3);
    chk(lg_data[0][0] == 16'h1111, "R4 input 0 write data kept", lg_data[0][0], 16'h1111);
    rep_drv(0, 16'h5a5a);
    idle(5);
    chk(n_rep[0] == 0 && n_rep[1] == 1 && rp_data[1][0] == 16'h5a5a, "R7 write left no queue entry",
        {n_rep[1], n_rep[0]}, 16'h0010);
  endtask

  task automatic t_backpressure();
    clear_logs();
    out0_ready = 1'b0;
    drv(1, 1, 0, 8'h00, 16'h0);
    drv(0, 0, 1, 8'h01, 16'h0);
    drv(0, 0, 1, 8'h02, 16'h0);
    drv(0, 0, 1, 8'h03, 16'h0);
    idle(4);
    chk(!in0_ready, "R8 input ready low when buffer full", in0_ready, 0);
    chk(out0_valid && out0_dest == 8'h01, "R8 stalled output held", out0_dest, 8'h01);
    out0_ready = 1'b1;
    drv(0, 1, 0, 8'h00, 16'h0);
    idle(8);
    chk(n_out[0] == 4 && lg_dest[0][0] == 8'h01 && lg_dest[0][1] == 8'h02 && lg_dest[0][2] == 8'h03
        && lg_eor[0][3], "R8 stream resumes in order", n_out[0], 4);
    chk(n_out[1] == 1 && lg_eor[1][0], "R8 marker on output 1 after release", n_out[1], 1);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      in_valid[k] = 1'b0; in_eor[k] = 1'b0; in_wr[k] = 1'b0; in_dest[k] = '0; in_data[k] = '0;
      rin_valid[k] = 1'b0; rin_data[k] = '0;
    end
    clear_logs();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sort_wait();
    t_route();
    t_eor_hold();
    t_merge_read();
    t_single_read();
    t_write_merge();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule